// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block collects single-cycle event pulses from a transfer engine into an eight-bit sticky status register and folds them, through an eight-bit enable mask, into one level-sensitive interrupt line. Transfer logic raises a bit with a set pulse, and it can also drop a bit with a clear pulse. Software sees both registers through a small strobe interface: one write strobe, one read strobe and a one-bit register select.

Software acknowledges events by writing ones to the status register. The two data-request flags (bit 0 receive, bit 1 transmit) stay under hardware control and ignore those writes. The packet-complete flag (bit 7) drives the interrupt line whatever the mask holds. Only mask bits 0, 1, 2, 3, 5 and 6 can be written.

Top module: `irq_status_ctrl`

## Requirements
- R1: A one on `evt_set[i]` at a clock edge leaves status bit i at one after that edge.
- R2: A write with `sel`=0 clears every status bit in positions 2 to 7 where `wdata` holds a one, and leaves the bits where `wdata` holds a zero unchanged.
- R3: Status bits 0 and 1 ignore software writes. Only `evt_clr` can bring them back to zero.
- R4: A one on `evt_clr[i]` at a clock edge clears status bit i, unless R5 applies.
- R5: When a set pulse and any clear (hardware or software) reach the same bit at the same edge, the bit ends at one.
- R6: A write with `sel`=1 loads the mask with `wdata & 8'h6F`. Mask bits 4 and 7 always read as zero.
- R7: `irq` equals the OR over all bits of status & (mask | 8'h80) as they stood one cycle earlier. It is a registered output.
- R8: A synchronous reset (`rst` high at a clock edge) clears status, mask, `irq` and `rdata`.
- R9: With `rd_en` high at an edge, `rdata` takes the status register (`sel`=0) or the mask (`sel`=1) as it stood before that edge. With `rd_en` low, `rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| sel | input | 1 | Register select: 0 status, 1 mask |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| evt_set | input | 8 | Per-bit hardware set pulses |
| evt_clr | input | 8 | Per-bit hardware clear pulses |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that the strobes and pulses are known, never X, in every cycle after reset. They put no limit on overlap: a set, a hardware clear and a software write may land on the same bit in one cycle. The random stimulus therefore drives all three sources together, with high density, so that the set-wins rule and the locked data-request bits are hit often. Directed steps before the random phase place each corner at a known point.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int IRQ_W = 8;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } reg_sel_e;

  // Event bit positions
  localparam int EV_RX_REQ   = 0;
  localparam int EV_TX_REQ   = 1;
  localparam int EV_ARB_LOST = 2;
  localparam int EV_NACK     = 3;
  localparam int EV_RX_UNDER = 4;
  localparam int EV_TX_OVER  = 5;
  localparam int EV_ALL_DONE = 6;
  localparam int EV_PKT_DONE = 7;
endpackage

// File: rtl/irq_status_bits.sv
module irq_status_bits #(
  parameter int W = 8,
  parameter logic [W-1:0] SW_LOCKED = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sw_clr_en,
  input  logic [W-1:0] sw_clr,
  input  logic [W-1:0] hw_set,
  input  logic [W-1:0] hw_clr,
  output logic [W-1:0] status
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic sw_hit;
    if (SW_LOCKED[i]) begin : g_locked
      assign sw_hit = 1'b0;
    end else begin : g_open
      assign sw_hit = sw_clr_en & sw_clr[i];
    end

    always_ff @(posedge clk) begin
      if (rst)            status[i] <= 1'b0;
      else if (hw_set[i]) status[i] <= 1'b1;
      else if (hw_clr[i] || sw_hit) status[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] WRITABLE = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] din,
  output logic [W-1:0] mask
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (WRITABLE[i]) begin : g_rw
      always_ff @(posedge clk) begin
        if (rst)     mask[i] <= 1'b0;
        else if (we) mask[i] <= din[i];
      end
    end else begin : g_ro
      assign mask[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_line.sv
module irq_line #(
  parameter int W = 8,
  parameter logic [W-1:0] FORCED = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] status,
  input  logic [W-1:0] mask,
  output logic         irq
);
  logic [W-1:0] live;
  assign live = status & (mask | FORCED);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |live;
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int W = IRQ_W,
  parameter logic [W-1:0] MASK_RW   = 8'h6F,
  parameter logic [W-1:0] SW_LOCKED = 8'h03,
  parameter logic [W-1:0] FORCED    = 8'h80
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic         sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] evt_set,
  input  logic [W-1:0] evt_clr,
  output logic         irq
);
  logic [W-1:0] status_q;
  logic [W-1:0] mask_q;
  logic         wr_status;
  logic         wr_mask;

  assign wr_status = wr_en && (reg_sel_e'(sel) == SEL_STATUS);
  assign wr_mask   = wr_en && (reg_sel_e'(sel) == SEL_MASK);

  irq_status_bits #(.W(W), .SW_LOCKED(SW_LOCKED)) u_status (
    .clk(clk), .rst(rst), .sw_clr_en(wr_status), .sw_clr(wdata),
    .hw_set(evt_set), .hw_clr(evt_clr), .status(status_q)
  );

  irq_mask_reg #(.W(W), .WRITABLE(MASK_RW)) u_mask (
    .clk(clk), .rst(rst), .we(wr_mask), .din(wdata), .mask(mask_q)
  );

  irq_line #(.W(W), .FORCED(FORCED)) u_line (
    .clk(clk), .rst(rst), .status(status_q), .mask(mask_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= (reg_sel_e'(sel) == SEL_MASK) ? mask_q : status_q;
  end
endmodule

module irq_status_chk #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK_RW   = 8'h6F,
  parameter logic [W-1:0] SW_LOCKED = 8'h03,
  parameter logic [W-1:0] FORCED    = 8'h80
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic         sel,
  input logic [W-1:0] wdata,
  input logic [W-1:0] evt_set,
  input logic [W-1:0] evt_clr,
  input logic [W-1:0] status,
  input logic [W-1:0] mask,
  input logic         irq
);
  // R1 R5
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_set != '0) |=> ((status & $past(evt_set)) == $past(evt_set)));

  // R3
  locked_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (((evt_set | evt_clr) & SW_LOCKED) == '0) |=>
      ((status & SW_LOCKED) == ($past(status) & SW_LOCKED)));

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel) |=> (mask == ($past(wdata) & MASK_RW)));

  // R7
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == |($past(status) & ($past(mask) | FORCED))));

  // R8
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (status == '0 && mask == '0 && !irq));
endmodule

bind irq_status_ctrl irq_status_chk #(
  .W(W), .MASK_RW(MASK_RW), .SW_LOCKED(SW_LOCKED), .FORCED(FORCED)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .wdata(wdata),
  .evt_set(evt_set), .evt_clr(evt_clr), .status(status_q),
  .mask(mask_q), .irq(irq)
);

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 0, rd_en = 0, sel = 0;
  logic [7:0] wdata = 0, evt_set = 0, evt_clr = 0;
  logic [7:0] rdata;
  logic       irq;

  int n_cmp = 0, n_bad = 0;
  int m_status = 0, m_mask = 0, m_rdata = 0, m_irq = 0;

  always #10 clk = ~clk;

  irq_status_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
    .wdata(wdata), .rdata(rdata), .evt_set(evt_set), .evt_clr(evt_clr),
    .irq(irq)
  );

  task automatic cmp(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a negedge: drive one cycle, advance model, compare at next negedge
  task automatic step(string tag, bit w, bit r, bit s, int wd, int st, int cl);
    int ns, nm, nr, ni;
    wr_en = w; rd_en = r; sel = s; wdata = 8'(wd); evt_set = 8'(st); evt_clr = 8'(cl);
    ni = ((m_status & (m_mask | 'h80)) != 0) ? 1 : 0;
    nr = r ? (s ? m_mask : m_status) : m_rdata;
    ns = m_status & ~cl & 'hFF;
    if (w && !s) ns = ns & ~(wd & 'hFC);
    ns = (ns | st) & 'hFF;
    nm = (w && s) ? (wd & 'h6F) : m_mask;
    m_status = ns; m_mask = nm; m_rdata = nr; m_irq = ni;
    @(negedge clk);
    cmp(tag, rdata, m_rdata);
    cmp("R7", irq, m_irq);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: state after reset
    cmp("R8", rdata, 0); cmp("R8", irq, 0);
    step("R8", 0, 1, 0, 0, 0, 0);
    step("R8", 0, 1, 1, 0, 0, 0);
    // R1: set all bits
    step("R9", 0, 0, 0, 0, 'hFF, 0);
    step("R1", 0, 1, 0, 0, 0, 0);
    cmp("R1", rdata, 'hFF);
    // R2 R3: software clear of all bits leaves 0x03
    step("R2", 1, 0, 0, 'hFF, 0, 0);
    step("R3", 0, 1, 0, 0, 0, 0);
    cmp("R3", rdata, 'h03);
    // R4: hardware clear of the locked pair
    step("R9", 0, 0, 0, 0, 0, 'h03);
    step("R4", 0, 1, 0, 0, 0, 0);
    cmp("R4", rdata, 'h00);
    // R5: set with both clears on bit 2, plain sw clear on bit 3
    step("R9", 0, 0, 0, 0, 'h0C, 0);
    step("R5", 1, 0, 0, 'h0C, 'h04, 'h04);
    step("R5", 0, 1, 0, 0, 0, 0);
    cmp("R5", rdata, 'h04);
    // R6: mask write all ones
    step("R6", 1, 0, 1, 'hFF, 0, 0);
    step("R6", 0, 1, 1, 0, 0, 0);
    cmp("R6", rdata, 'h6F);
    // R7: bit 7 raises irq with zero mask
    step("R6", 1, 0, 1, 0, 0, 0);
    step("R2", 1, 0, 0, 'hFC, 0, 0);
    step("R7", 0, 0, 0, 0, 'h80, 0);
    step("R7", 0, 0, 0, 0, 0, 0);
    cmp("R7", irq, 1);
    // R9: rdata holds with no read strobe
    step("R9", 0, 0, 1, 0, 'h10, 0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      step("R9", ($urandom % 3) == 0, $urandom % 2, $urandom % 2, $urandom,
           ($urandom % 2) ? ($urandom & $urandom) : 0,
           ($urandom % 2) ? ($urandom & $urandom) : 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule